// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block decides, cycle by cycle, whether a bank of differential clock outputs is driven or left tri-stated. It watches an active-low power-down request, a power-good level, an indication that the input reference clock is valid and a PLL lock indication. All of these arrive as digital signals. The request is passed through a two-flop synchronizer. A power-down counts only after two consecutive low samples on rising edges of the sampling clock. The outputs are then released to tri-state on the following falling edge, so no output pulse is cut short.

Power-up starts when power-good and a valid input clock are both present. The outputs stay tri-stated until the PLL reports lock, and a sticky flag is raised if lock does not arrive within a parameterized number of cycles. Leaving power-down follows the same lock-wait path under a separate cycle budget, with its own flag. Every output has an enable for its true leg and one for its complement leg, and both enables always carry the same value.

Top module: `clk_pwrdn_seq`

## Requirements
- R1: `pwrdn_req_n` passes through two synchronizer flops. It must then be sampled low on two consecutive rising edges of `clk` before a power-down is taken. A low held from the drive point before rising edge P1 removes the drive at the falling edge after rising edge P4.
- R2: A single high synchronized sample clears any partial count of low samples, and counting starts again from zero. A low lasting one cycle never stops the outputs.
- R3: Once a power-down is qualified, every output enable goes to 0 (tri-state) on the next falling edge of `clk`. The enables stay 0 for as long as the request is held low.
- R4: While `pwr_good` is low, every enable is 0 whatever the value of `pwrdn_req_n`. The enables drop on the first falling edge at which `pwr_good` is seen low.
- R5: Power-up begins only with `pwr_good` and `ref_clk_ok` both high. The enables become 1 only after `pll_lock` is seen high in the lock-wait phase. With lock already present, the enables rise at the falling edge after the second rising edge that follows the inputs.
- R6: If lock-wait during power-up lasts LOCK_LIMIT cycles without lock, `lock_late` goes to 1. It stays 1 until the next lock-wait phase begins.
- R7: When the request returns high after a power-down, the block re-enters lock-wait and drives the outputs again once lock is seen. If lock is absent for DRIVE_LIMIT cycles, `drive_late` goes to 1.
- R8: `oe_true` and `oe_comp` are equal at all times, and all N_OUT bits in each carry the same value.
- R9: During and right after reset, all enables are 0 and both late flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (complementary output clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_req_n | input | 1 | Active-low power-down request, asynchronous |
| pwr_good | input | 1 | Power-good level |
| ref_clk_ok | input | 1 | Input reference clock valid |
| pll_lock | input | 1 | PLL lock indication |
| oe_true | output | N_OUT | Drive enable, true legs (1 = driven, 0 = tri-state) |
| oe_comp | output | N_OUT | Drive enable, complement legs |
| lock_late | output | 1 | Power-up lock budget exceeded |
| drive_late | output | 1 | Release-from-power-down budget exceeded |

## Verification
Directed patterns separate a one-cycle low request (R2) from a held low (R1, R3) and check the exact falling edge at which the drive stops. A power-up with lock withheld pins down the cycle at which the timeout flag rises, and the same check is made for release from power-down. Dropping power-good with the request toggling shows that power-good overrides the request. A long seeded random run then mixes request glitches, lock loss and power-good drops against a cycle model kept in the bench, which exposes ordering and priority errors the directed cases miss.

// File: rtl/clk_pd_pkg.sv
package clk_pd_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_LOCKWAIT = 2'd1,
        ST_ON       = 2'd2,
        ST_PDOWN    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/pd_sync2.sv
module pd_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = async_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: RESET_VAL, s2: RESET_VAL};
        else        r_q <= r_d;
    end

    assign sync_o = r_q.s2;
endmodule

// File: rtl/pd_qualifier.sv
module pd_qualifier #(
    parameter int unsigned NEED_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_s,
    output logic pd_active
);
    localparam int unsigned CW = $clog2(NEED_LOW + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (req_n_s)                      cnt_d = '0;
        else if (cnt_q != CW'(NEED_LOW))  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pd_active = (cnt_q == CW'(NEED_LOW));

    assert_high_cancels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_n_s |=> !pd_active);

    assert_qualified_after_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> !$past(req_n_s));
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import clk_pd_pkg::*;
#(
    parameter int unsigned LOCK_LIMIT  = 180000,
    parameter int unsigned DRIVE_LIMIT = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic ref_clk_ok,
    input  logic pll_lock,
    input  logic pd_active,
    output logic run_on,
    output logic lock_late,
    output logic drive_late
);
    localparam int unsigned MAX_LIMIT = (LOCK_LIMIT > DRIVE_LIMIT) ? LOCK_LIMIT : DRIVE_LIMIT;
    localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] timer;
        logic             from_pd;
        logic             lock_to;
        logic             drive_to;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [CNT_W-1:0] limit_sel;
    logic [CNT_W-1:0] timer_inc;

    always_comb begin
        limit_sel = r_q.from_pd ? CNT_W'(DRIVE_LIMIT) : CNT_W'(LOCK_LIMIT);
        timer_inc = r_q.timer + 1'b1;
        r_d = r_q;
        if (!pwr_good) begin
            r_d.state = ST_OFF;
        end else if (pd_active) begin
            r_d.state = ST_PDOWN;
        end else begin
            case (r_q.state)
                ST_OFF: begin
                    if (ref_clk_ok) begin
                        r_d.state    = ST_LOCKWAIT;
                        r_d.timer    = '0;
                        r_d.from_pd  = 1'b0;
                        r_d.lock_to  = 1'b0;
                        r_d.drive_to = 1'b0;
                    end
                end
                ST_PDOWN: begin
                    if (ref_clk_ok) begin
                        r_d.state    = ST_LOCKWAIT;
                        r_d.timer    = '0;
                        r_d.from_pd  = 1'b1;
                        r_d.lock_to  = 1'b0;
                        r_d.drive_to = 1'b0;
                    end else begin
                        r_d.state = ST_OFF;
                    end
                end
                ST_LOCKWAIT: begin
                    if (!ref_clk_ok) begin
                        r_d.state = ST_OFF;
                    end else if (pll_lock) begin
                        r_d.state = ST_ON;
                    end else begin
                        if (r_q.timer != limit_sel) r_d.timer = timer_inc;
                        if (timer_inc == limit_sel) begin
                            if (r_q.from_pd) r_d.drive_to = 1'b1;
                            else             r_d.lock_to  = 1'b1;
                        end
                    end
                end
                default: r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_OFF, timer: '0, from_pd: 1'b0, lock_to: 1'b0, drive_to: 1'b0};
        else        r_q <= r_d;
    end

    assign run_on     = (r_q.state == ST_ON);
    assign lock_late  = r_q.lock_to;
    assign drive_late = r_q.drive_to;

    assert_no_enable_without_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOCKWAIT && !pll_lock) |=> r_q.state != ST_ON);

    assert_lock_flag_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.lock_to) |-> (r_q.state == ST_LOCKWAIT && !r_q.from_pd));

    assert_drive_flag_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.drive_to) |-> (r_q.state == ST_LOCKWAIT && r_q.from_pd));
endmodule

// File: rtl/pd_out_stage.sv
module pd_out_stage #(
    parameter int unsigned N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_on,
    input  logic             pd_active,
    input  logic             pwr_good,
    output logic [N_OUT-1:0] oe_true,
    output logic [N_OUT-1:0] oe_comp
);
    logic             drive_d;
    logic [N_OUT-1:0] oe_q;

    always_comb drive_d = run_on && !pd_active && pwr_good;

    for (genvar g = 0; g < N_OUT; g++) begin : g_leg
        logic oe_d;
        always_comb oe_d = drive_d;
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) oe_q[g] <= 1'b0;
            else        oe_q[g] <= oe_d;
        end
        assign oe_true[g] = oe_q[g];
        assign oe_comp[g] = oe_q[g];
    end

    assert_stop_on_fall_R3: assert property (@(negedge clk) disable iff (!rst_n)
        pd_active |=> (oe_q == '0));

    assert_pgood_low_tristate_R4: assert property (@(negedge clk) disable iff (!rst_n)
        !pwr_good |=> (oe_q == '0));

    assert_legs_uniform_R8: assert property (@(negedge clk) disable iff (!rst_n)
        (oe_q == '0) || (oe_q == '1));
endmodule

// File: rtl/clk_pwrdn_seq.sv
module clk_pwrdn_seq #(
    parameter int unsigned N_OUT       = 4,
    parameter int unsigned LOCK_LIMIT  = 180000,
    parameter int unsigned DRIVE_LIMIT = 30000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrdn_req_n,
    input  logic             pwr_good,
    input  logic             ref_clk_ok,
    input  logic             pll_lock,
    output logic [N_OUT-1:0] oe_true,
    output logic [N_OUT-1:0] oe_comp,
    output logic             lock_late,
    output logic             drive_late
);
    logic req_n_s;
    logic pd_active;
    logic run_on;

    pd_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwrdn_req_n),
        .sync_o  (req_n_s)
    );

    pd_qualifier #(.NEED_LOW(2)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n_s   (req_n_s),
        .pd_active (pd_active)
    );

    pd_seq_fsm #(.LOCK_LIMIT(LOCK_LIMIT), .DRIVE_LIMIT(DRIVE_LIMIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .ref_clk_ok (ref_clk_ok),
        .pll_lock   (pll_lock),
        .pd_active  (pd_active),
        .run_on     (run_on),
        .lock_late  (lock_late),
        .drive_late (drive_late)
    );

    pd_out_stage #(.N_OUT(N_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_on    (run_on),
        .pd_active (pd_active),
        .pwr_good  (pwr_good),
        .oe_true   (oe_true),
        .oe_comp   (oe_comp)
    );
endmodule

// File: tb/clk_pwrdn_seq_tb_top.sv
module clk_pwrdn_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_OUT      = 4;
    localparam int LOCK_LIM   = 12;
    localparam int DRIVE_LIM  = 8;

    localparam logic [1:0] M_OFF = 2'd0, M_WAIT = 2'd1, M_ON = 2'd2, M_PD = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_req_n = 1'b1, pwr_good = 1'b0, ref_clk_ok = 1'b0, pll_lock = 1'b0;
    logic [N_OUT-1:0] oe_true, oe_comp;
    logic lock_late, drive_late;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_pwrdn_seq #(.N_OUT(N_OUT), .LOCK_LIMIT(LOCK_LIM), .DRIVE_LIMIT(DRIVE_LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwrdn_req_n(pwrdn_req_n), .pwr_good(pwr_good),
        .ref_clk_ok(ref_clk_ok), .pll_lock(pll_lock), .oe_true(oe_true), .oe_comp(oe_comp),
        .lock_late(lock_late), .drive_late(drive_late)
    );

    // Cycle model built from the requirements
    logic m_s1, m_s2, m_from_pd, m_lto, m_dto, m_oe;
    logic [1:0] m_cnt, m_st;
    int m_tmr;

    function automatic int lim_of(input logic from_pd);
        return from_pd ? DRIVE_LIM : LOCK_LIM;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_cnt <= 2'd0; m_st <= M_OFF;
            m_tmr <= 0; m_from_pd <= 1'b0; m_lto <= 1'b0; m_dto <= 1'b0;
        end else begin
            m_s1 <= pwrdn_req_n;
            m_s2 <= m_s1;
            m_cnt <= m_s2 ? 2'd0 : ((m_cnt == 2'd2) ? 2'd2 : m_cnt + 2'd1);
            if (!pwr_good) m_st <= M_OFF;
            else if (m_cnt == 2'd2) m_st <= M_PD;
            else if (m_st == M_OFF || m_st == M_PD) begin
                if (ref_clk_ok) begin
                    m_st <= M_WAIT; m_tmr <= 0; m_from_pd <= (m_st == M_PD);
                    m_lto <= 1'b0; m_dto <= 1'b0;
                end else m_st <= M_OFF;
            end else if (m_st == M_WAIT) begin
                if (!ref_clk_ok) m_st <= M_OFF;
                else if (pll_lock) m_st <= M_ON;
                else begin
                    if (m_tmr != lim_of(m_from_pd)) m_tmr <= m_tmr + 1;
                    if (m_tmr + 1 == lim_of(m_from_pd)) begin
                        if (m_from_pd) m_dto <= 1'b1; else m_lto <= 1'b1;
                    end
                end
            end
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) m_oe <= 1'b0;
        else        m_oe <= (m_st == M_ON) && (m_cnt != 2'd2) && pwr_good;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic [N_OUT-1:0] ev;
        ev = {N_OUT{m_oe}};
        check(oe_true == ev, "R3 model oe_true", 32'(oe_true), 32'(ev));
        check(oe_comp == ev, "R8 model oe_comp", 32'(oe_comp), 32'(ev));
        check(lock_late == m_lto, "R6 model lock_late", 32'(lock_late), 32'(m_lto));
        check(drive_late == m_dto, "R7 model drive_late", 32'(drive_late), 32'(m_dto));
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            compare_model();
        end
    endtask

    localparam logic [N_OUT-1:0] ALL1 = '1;

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        // R9 reset state
        tick(3);
        check(oe_true == '0 && oe_comp == '0, "R9 reset enables", 32'(oe_true), 0);
        check(!lock_late && !drive_late, "R9 reset flags", 32'({lock_late, drive_late}), 0);
        rst_n = 1'b1;
        tick(2);
        check(oe_true == '0, "R9 after reset", 32'(oe_true), 0);

        // R5/R6 power-up with lock withheld
        pwr_good = 1'b1; ref_clk_ok = 1'b1;
        tick(LOCK_LIM);
        check(lock_late == 1'b0, "R6 flag not yet", 32'(lock_late), 0);
        check(oe_true == '0, "R5 no enable before lock", 32'(oe_true), 0);
        tick(1);
        check(lock_late == 1'b1, "R6 flag at limit", 32'(lock_late), 1);
        pll_lock = 1'b1;
        tick(1);
        check(oe_true == '0, "R5 enable not yet", 32'(oe_true), 0);
        tick(1);
        check(oe_true == ALL1, "R5 enabled after lock", 32'(oe_true), 32'(ALL1));
        check(oe_comp == oe_true, "R8 legs equal", 32'(oe_comp), 32'(oe_true));

        // R2 one-cycle low request is cancelled
        pwrdn_req_n = 1'b0; tick(1); pwrdn_req_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            check(oe_true == ALL1, "R2 glitch ignored", 32'(oe_true), 32'(ALL1));
        end

        // R1/R3 held request stops outputs on the qualified falling edge
        pwrdn_req_n = 1'b0;
        tick(4);
        check(oe_true == ALL1, "R1 still driven before qualify", 32'(oe_true), 32'(ALL1));
        tick(1);
        check(oe_true == '0, "R1 stopped after two low samples", 32'(oe_true), 0);
        check(oe_comp == '0, "R3 complement stopped", 32'(oe_comp), 0);
        for (int i = 0; i < 5; i++) begin
            tick(1);
            check(oe_true == '0, "R3 held stopped", 32'(oe_true), 0);
        end

        // R7 release with lock lost: drive budget flag, then drive on lock
        pll_lock = 1'b0; pwrdn_req_n = 1'b1;
        tick(3 + DRIVE_LIM);
        check(drive_late == 1'b0, "R7 drive flag not yet", 32'(drive_late), 0);
        tick(1);
        check(drive_late == 1'b1, "R7 drive flag at limit", 32'(drive_late), 1);
        pll_lock = 1'b1;
        tick(2);
        check(oe_true == ALL1, "R7 driven after release", 32'(oe_true), 32'(ALL1));

        // R4 power-good low overrides request
        pwr_good = 1'b0;
        tick(1);
        check(oe_true == '0, "R4 pgood low stops", 32'(oe_true), 0);
        for (int i = 0; i < 6; i++) begin
            pwrdn_req_n = i[0];
            tick(1);
            check(oe_true == '0, "R4 stays tri-state", 32'(oe_true), 0);
        end
        pwrdn_req_n = 1'b1; pwr_good = 1'b1;
        tick(6);

        // Seeded random phase against the cycle model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) pwrdn_req_n = ~pwrdn_req_n;
            pwr_good   = ($urandom_range(0, 99) != 0);
            ref_clk_ok = ($urandom_range(0, 49) != 0);
            if ($urandom_range(0, 19) == 0) pll_lock = ~pll_lock;
            tick(1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule